// File: doc/BRIEF.md
# Cyclic Permutation Crossbar Sequencer

This block is a time-slotted N-by-N interconnect for a load-balanced switch fabric. A modulo-N slot counter picks one cyclic permutation per clock. In slot `t`, input lane `j` is connected to output lane `(j + t) mod N`, with 0-based lane and slot numbers. Across any N consecutive slots, every input meets every output exactly once. Each connection carries 1/N of a lane's capacity over the window. No requests, grants or arbitration are involved.

Upstream logic reads the slot index, so it knows which destination each input lane reaches in the current cycle. It then presents the cell meant for that destination. Each lane carries a cell and a valid flag. The outputs are registered, so a cell presented in slot `t` appears on its output one clock later.

Top module: `cpx_crossbar`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state has `slot_idx` = 0, all `out_valid` bits 0 and all `out_data` lanes 0.
- R2: Outside reset, `slot_idx` advances by one on every clock and wraps from N-1 back to 0.
- R3: A cell presented on input lane j while `slot_idx` = t appears on output lane (j+t) mod N with the same data. Lane k occupies bits [k*CELL_W +: CELL_W] of the packed data buses.
- R4: The latency from input to output is exactly one clock; outputs change only at rising clock edges.
- R5: An output lane whose connected input was idle shows `out_valid` = 0 and `out_data` = 0 in the next cycle.
- R6: Each output carries at most one cell per slot, and the number of valid outputs equals the number of valid inputs in the previous cycle.
- R7: Over any N consecutive slots with all inputs valid, each input lane is delivered to each output lane exactly once.
- R8: Data on an input lane whose valid flag is 0 is ignored and never reaches any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | N_PORTS*CELL_W | Packed input cells, lane k at [k*CELL_W +: CELL_W] |
| in_valid | input | N_PORTS | Input valid flag per lane |
| out_data | output | N_PORTS*CELL_W | Packed registered output cells |
| out_valid | output | N_PORTS | Output valid flag per lane |
| slot_idx | output | SLOT_W | Current slot t, selecting the permutation applied to the present inputs |

## Verification
The assertions assume that `rst` is driven synchronously and that input data may be any value, including garbage on idle lanes. No other input constraint applies, because every combination of valid flags is legal in every slot. The stimulus changes inputs only on falling edges. It mixes random valid patterns, all-idle and all-valid slots, and idle lanes loaded with non-zero junk. It runs a full all-valid window to check the exactly-once coverage, and it applies a reset in the middle of a run to check that the slot sequence restarts.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

    // Add two lane or slot numbers modulo n; both operands are below n.
    function automatic int wrap_add(input int a, input int b, input int n);
        int s;
        s = a + b;
        return (s >= n) ? s - n : s;
    endfunction

endpackage

// File: rtl/cpx_slot_counter.sv
module cpx_slot_counter #(
    parameter int N_SLOTS = 4,
    localparam int SW = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    output logic [SW-1:0] slot
);
    localparam logic [SW-1:0] LAST = SW'(N_SLOTS - 1);

    logic [SW-1:0] slot_d, slot_q;

    always_comb begin
        if (rst)                slot_d = '0;
        else if (slot_q == LAST) slot_d = '0;
        else                    slot_d = slot_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_d;
    end

    assign slot = slot_q;

    // R2: wrap from the last slot to zero
    p_slot_wrap_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_q == LAST) |=> (slot_q == '0));

    // R2: single step otherwise
    p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_q != LAST) |=> (slot_q == $past(slot_q) + 1'b1));
endmodule

// File: rtl/cpx_rotator.sv
module cpx_rotator #(
    parameter int N_PORTS = 4,
    parameter int CELL_W  = 8,
    localparam int SW = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic [N_PORTS*CELL_W-1:0] in_data,
    input  logic [N_PORTS-1:0]        in_valid,
    input  logic [SW-1:0]             slot,
    output logic [N_PORTS*CELL_W-1:0] rot_data,
    output logic [N_PORTS-1:0]        rot_valid
);
    always_comb begin
        rot_data  = '0;
        rot_valid = '0;
        for (int j = 0; j < N_PORTS; j++) begin
            int dst;
            dst = cpx_pkg::wrap_add(j, int'(slot), N_PORTS);
            rot_valid[dst] = in_valid[j];
            rot_data[dst*CELL_W +: CELL_W] =
                in_valid[j] ? in_data[j*CELL_W +: CELL_W] : '0;
        end
    end
endmodule

// File: rtl/cpx_crossbar.sv
module cpx_crossbar #(
    parameter int N_PORTS = 4,
    parameter int CELL_W  = 8,
    localparam int SLOT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_PORTS*CELL_W-1:0] in_data,
    input  logic [N_PORTS-1:0]        in_valid,
    output logic [N_PORTS*CELL_W-1:0] out_data,
    output logic [N_PORTS-1:0]        out_valid,
    output logic [SLOT_W-1:0]         slot_idx
);
    typedef struct packed {
        logic [N_PORTS*CELL_W-1:0] data;
        logic [N_PORTS-1:0]        valid;
    } out_reg_t;

    out_reg_t                  out_d, out_q;
    logic [SLOT_W-1:0]         slot;
    logic [N_PORTS*CELL_W-1:0] rot_data;
    logic [N_PORTS-1:0]        rot_valid;

    cpx_slot_counter #(.N_SLOTS(N_PORTS)) u_slot (
        .clk  (clk),
        .rst  (rst),
        .slot (slot)
    );

    cpx_rotator #(.N_PORTS(N_PORTS), .CELL_W(CELL_W)) u_rot (
        .in_data   (in_data),
        .in_valid  (in_valid),
        .slot      (slot),
        .rot_data  (rot_data),
        .rot_valid (rot_valid)
    );

    always_comb begin
        if (rst) begin
            out_d = '0;
        end else begin
            out_d.data  = rot_data;
            out_d.valid = rot_valid;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign out_data  = out_q.data;
    assign out_valid = out_q.valid;
    assign slot_idx  = slot;

    // R1: reset clears slot and outputs
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (slot_idx == '0 && out_valid == '0 && out_data == '0));

    // R6: cells are conserved through the permutation
    p_cell_count_r6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(out_valid) == $past($countones(in_valid))));

    // R5: an idle output lane carries zero data
    for (genvar o = 0; o < N_PORTS; o++) begin : g_idle
        p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
            !out_valid[o] |-> (out_data[o*CELL_W +: CELL_W] == '0));
    end
endmodule

// File: tb/cpx_crossbar_tb.sv
module cpx_crossbar_tb;
    localparam int N = 4;
    localparam int W = 8;
    localparam int SW = 2;
    localparam int CLK_PERIOD = 10;

    logic           clk = 0;
    logic           rst = 1;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   in_valid = '0;
    logic [N*W-1:0] out_data;
    logic [N-1:0]   out_valid;
    logic [SW-1:0]  slot_idx;

    int checks = 0;
    int errors = 0;
    int m_slot = 0;
    int exp_v[N];
    int exp_d[N];
    int hits[N][N];
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpx_crossbar #(.N_PORTS(N), .CELL_W(W)) u_dut (
        .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid),
        .out_data(out_data), .out_valid(out_valid), .slot_idx(slot_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model: compute what each output should carry after this slot.
    task automatic model_step();
        for (int o = 0; o < N; o++) begin
            exp_v[o] = 0;
            exp_d[o] = 0;
        end
        for (int j = 0; j < N; j++) begin
            int dst;
            dst = (j + m_slot) % N;
            if (in_valid[j]) begin
                exp_v[dst] = 1;
                exp_d[dst] = int'(in_data[j*W +: W]);
            end
        end
        m_slot = (m_slot + 1) % N;
    endtask

    task automatic compare(input string req);
        chk(int'(slot_idx) == m_slot, "R2 slot", int'(slot_idx), m_slot);
        for (int o = 0; o < N; o++) begin
            chk(int'(out_valid[o]) == exp_v[o], {req, " R3 valid"}, int'(out_valid[o]), exp_v[o]);
            chk(int'(out_data[o*W +: W]) == exp_d[o], {req, " R3 data"},
                int'(out_data[o*W +: W]), exp_d[o]);
        end
    endtask

    task automatic drive(input logic [N-1:0] v, input logic [N*W-1:0] d);
        in_valid = v;
        in_data  = d;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(slot_idx == '0, "R1 slot", int'(slot_idx), 0);
        chk(out_valid == '0, "R1 valid", int'(out_valid), 0);
        chk(out_data == '0, "R1 data", int'(out_data), 0);

        rst = 0;
        m_slot = 0;
        drive('1, 32'h44332211);
        model_step();
        // R4: before the edge, nothing visible yet
        #1 chk(out_valid == '0, "R4 no early output", int'(out_valid), 0);

        for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            compare("R4");
            if (k % 5 == 0)      drive('0, $urandom());           // R5/R8: all idle, junk data
            else if (k % 5 == 1) drive('1, $urandom());
            else                 drive(N'($urandom()), $urandom()); // R8: junk on idle lanes
            model_step();
        end

        // R7: a full window starting at slot 0 with tagged cells
        while (m_slot != 0) begin
            @(negedge clk);
            compare("R7 align");
            drive('0, '1);
            model_step();
        end
        for (int a = 0; a < N; a++) for (int b = 0; b < N; b++) hits[a][b] = 0;
        for (int k = 0; k <= N; k++) begin
            @(negedge clk);
            compare("R7");
            if (k > 0)
                for (int o = 0; o < N; o++)
                    if (out_valid[o] && int'(out_data[o*W +: W]) < N)
                        hits[int'(out_data[o*W +: W])][o]++;
            if (k < N) drive('1, {8'd3, 8'd2, 8'd1, 8'd0});
            else       drive('0, '0);
            model_step();
        end
        for (int a = 0; a < N; a++)
            for (int b = 0; b < N; b++)
                chk(hits[a][b] == 1, "R7 exactly once", hits[a][b], 1);

        // R6: count of cells preserved
        @(negedge clk);
        compare("R6");
        drive(4'b1010, 32'hA5A5A5A5);
        model_step();
        @(negedge clk);
        chk($countones(out_valid) == 2, "R6 count", $countones(out_valid), 2);
        compare("R6");

        // R1: mid-run reset restarts the slot sequence
        rst = 1;
        drive('1, 32'hDEADBEEF);
        @(negedge clk);
        chk(slot_idx == '0, "R1 mid slot", int'(slot_idx), 0);
        chk(out_valid == '0, "R1 mid valid", int'(out_valid), 0);
        chk(out_data == '0, "R1 mid data", int'(out_data), 0);
        rst = 0;
        m_slot = 0;
        drive(4'b0001, 32'h0000007E);
        model_step();
        @(negedge clk);
        compare("R3 after reset");
        chk(int'(out_data[7:0]) == 8'h7E && out_valid == 4'b0001, "R3 slot0 lane0",
            int'(out_valid), 1);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                chk(0, "watchdog", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule